// File: doc/BRIEF.md
# Per-Cluster Attraction Buffer

In a clustered processor whose first-level cache is split word by word across the clusters, every cluster owns a cache module that holds only its share of each cache block. A load to a word held in another cluster's module pays the cost of the remote path. The attraction buffer sits next to the local cache module and keeps copies of remote subblocks, so that repeated remote accesses can be served locally. Once a remote load returns, the whole subblock is captured. A later load to either word of that subblock then completes in a single cycle.

Copies of the same subblock may exist in several clusters' buffers, but only as read-only copies. A store that hits the buffer updates its own copy, marks it as owned, and sends an invalidate for that subblock to the other clusters. Each of those drops its copy, so a modified word lives in only one buffer. Stores are also written through to the home module, so no write-back is ever needed. The loop scheduler issues a flush at the end of a loop. The flush empties the buffer in one cycle and stalls lookups during that cycle. Replacement is least-recently-used over a fully associative set of entries.

Top module: `attraction_buffer`

## Requirements
- R1: While reset is held, and after it is released, the buffer is empty, and rd_valid and inv_out_valid are low.
- R2: A word address splits into a home-cluster field in the low log2(NUM_CLUSTERS) bits, then a word-select field of log2(WORDS) bits, then the block field above them. The subblock tag is {block, home}. fill_data word w sits at bits [w*DATA_W +: DATA_W]. A captured fill makes a later load to any word of that subblock hit, with that word's data.
- R3: A load request gives rd_valid exactly one cycle later. On a hit it also gives rd_hit=1 and the stored word. On a miss it gives rd_hit=0 and rd_data=0.
- R4: A fill whose home field equals CLUSTER_ID is not captured, so later loads to it miss.
- R5: A fill for a tag that is already held leaves that entry's data unchanged. This holds for both read-only and owned entries.
- R6: A store that hits replaces the addressed word and marks the entry owned. One cycle later it raises inv_out_valid for one cycle, with inv_out_tag equal to the subblock tag. A store that misses changes nothing and sends no invalidate.
- R7: inv_in_valid with a held tag drops that entry, whether it is read-only or owned. In the same cycle, an invalidate beats a fill or a store to the same tag.
- R8: Fills go to an empty entry first, choosing the lowest index. When every entry is full, a fill evicts the least recently used entry. Fills, store hits and load hits count as uses, with at most one use recorded per cycle, in that priority order.
- R9: While flush is high, ld_stall is high and every other request in that cycle is ignored. A load issued in that cycle yields rd_valid=0, and afterwards every entry is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | End-of-loop flush command |
| ld_stall | output | 1 | Lookup stalled this cycle |
| ld_req | input | 1 | Load lookup request |
| ld_addr | input | ADDR_W | Load word address |
| rd_valid | output | 1 | Lookup result valid |
| rd_hit | output | 1 | Lookup found the word |
| rd_data | output | DATA_W | Word returned on a hit |
| fill_valid | input | 1 | Remote subblock returned |
| fill_tag | input | ADDR_W-log2(WORDS) | Tag of the returned subblock |
| fill_data | input | WORDS*DATA_W | Subblock words |
| st_valid | input | 1 | Store from this cluster |
| st_addr | input | ADDR_W | Store word address |
| st_data | input | DATA_W | Store data |
| inv_in_valid | input | 1 | Invalidate from another cluster |
| inv_in_tag | input | ADDR_W-log2(WORDS) | Tag to drop |
| inv_out_valid | output | 1 | Invalidate broadcast to other clusters |
| inv_out_tag | output | ADDR_W-log2(WORDS) | Tag being invalidated |

## Verification
The bench builds the buffer with four entries, four clusters, two words per subblock, 10-bit addresses, 16-bit data and CLUSTER_ID=1. With four entries, the buffer fills after only four fills, so the eviction order can be observed with a short sequence. With CLUSTER_ID=1, the same address space holds both local subblocks (home field 1) and remote ones (home fields 0, 2 and 3). Two words per subblock let the bench check that a capture also serves the partner word of the one that missed.

// File: rtl/ab_pkg.sv
package ab_pkg;

    typedef enum logic [1:0] {
        LINE_EMPTY  = 2'd0,
        LINE_SHARED = 2'd1,
        LINE_OWNED  = 2'd2
    } line_state_e;

    function automatic logic line_live(line_state_e s);
        return s != LINE_EMPTY;
    endfunction

endpackage

// File: rtl/ab_match.sv
module ab_match #(
    parameter int ENTRIES = 8,
    parameter int TAG_W   = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0]            live,
    input  logic [ENTRIES-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]              key,
    output logic [ENTRIES-1:0]            hit_vec,
    output logic                          hit,
    output logic [IDX_W-1:0]              hit_idx
);
    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
        assign hit_vec[e] = live[e] && (tags[e] == key);
    end

    assign hit = |hit_vec;

    always_comb begin
        hit_idx = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (hit_vec[e]) hit_idx = IDX_W'(e);
        end
    end
endmodule

// File: rtl/ab_lru.sv
module ab_lru #(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               touch_en,
    input  logic [IDX_W-1:0]   touch_idx,
    input  logic [ENTRIES-1:0] live,
    output logic [IDX_W-1:0]   victim_idx
);
    logic [ENTRIES-1:0][IDX_W-1:0] age_q;
    logic [ENTRIES-1:0]            oldest_vec;
    logic                          free_found;

    // ages form a permutation: 0 = most recent, ENTRIES-1 = least recent
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) age_q[i] <= IDX_W'(i);
        end else if (touch_en) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (IDX_W'(i) == touch_idx)
                    age_q[i] <= '0;
                else if (age_q[i] < age_q[touch_idx])
                    age_q[i] <= age_q[i] + 1'b1;
            end
        end
    end

    for (genvar i = 0; i < ENTRIES; i++) begin : g_old
        assign oldest_vec[i] = (age_q[i] == IDX_W'(ENTRIES-1));
    end

    always_comb begin
        victim_idx = '0;
        free_found = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!live[i] && !free_found) begin
                victim_idx = IDX_W'(i);
                free_found = 1'b1;
            end
        end
        if (!free_found) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (oldest_vec[i]) victim_idx = IDX_W'(i);
            end
        end
    end

    // R8
    lru_single_oldest_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(oldest_vec) == 1);
endmodule

// File: rtl/attraction_buffer.sv
module attraction_buffer
    import ab_pkg::*;
#(
    parameter int NUM_CLUSTERS = 4,
    parameter int CLUSTER_ID   = 0,
    parameter int WORDS        = 2,
    parameter int ENTRIES      = 8,
    parameter int ADDR_W       = 16,
    parameter int DATA_W       = 32,
    localparam int CL_W        = $clog2(NUM_CLUSTERS),
    localparam int WS_W        = $clog2(WORDS),
    localparam int TAG_W       = ADDR_W - WS_W,
    localparam int IDX_W       = $clog2(ENTRIES)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    flush,
    output logic                    ld_stall,
    input  logic                    ld_req,
    input  logic [ADDR_W-1:0]       ld_addr,
    output logic                    rd_valid,
    output logic                    rd_hit,
    output logic [DATA_W-1:0]       rd_data,
    input  logic                    fill_valid,
    input  logic [TAG_W-1:0]        fill_tag,
    input  logic [WORDS*DATA_W-1:0] fill_data,
    input  logic                    st_valid,
    input  logic [ADDR_W-1:0]       st_addr,
    input  logic [DATA_W-1:0]       st_data,
    input  logic                    inv_in_valid,
    input  logic [TAG_W-1:0]        inv_in_tag,
    output logic                    inv_out_valid,
    output logic [TAG_W-1:0]        inv_out_tag
);
    typedef struct packed {
        logic              valid;
        logic              hit;
        logic [DATA_W-1:0] data;
    } rd_resp_t;

    typedef struct packed {
        logic             valid;
        logic [TAG_W-1:0] tag;
    } inv_msg_t;

    line_state_e                   state_q [ENTRIES];
    logic [ENTRIES-1:0][TAG_W-1:0] tag_q;
    logic [DATA_W-1:0]             data_q  [ENTRIES][WORDS];
    logic [ENTRIES-1:0]            live;

    rd_resp_t rd_q;
    inv_msg_t inv_q;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_live
        assign live[e] = line_live(state_q[e]);
    end

    // address split: {block, word select, home cluster}
    logic [TAG_W-1:0] ld_tag, st_tag;
    logic [WS_W-1:0]  ld_ws, st_ws;
    assign ld_tag = {ld_addr[ADDR_W-1:CL_W+WS_W], ld_addr[CL_W-1:0]};
    assign st_tag = {st_addr[ADDR_W-1:CL_W+WS_W], st_addr[CL_W-1:0]};
    assign ld_ws  = ld_addr[CL_W +: WS_W];
    assign st_ws  = st_addr[CL_W +: WS_W];

    logic [ENTRIES-1:0] ld_vec, st_vec, fl_vec, iv_vec;
    logic               ld_hit, st_hit, fl_hit, iv_hit;
    logic [IDX_W-1:0]   ld_idx, st_idx, fl_idx, iv_idx;

    ab_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_ld_match (
        .live(live), .tags(tag_q), .key(ld_tag),
        .hit_vec(ld_vec), .hit(ld_hit), .hit_idx(ld_idx));
    ab_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_st_match (
        .live(live), .tags(tag_q), .key(st_tag),
        .hit_vec(st_vec), .hit(st_hit), .hit_idx(st_idx));
    ab_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_fl_match (
        .live(live), .tags(tag_q), .key(fill_tag),
        .hit_vec(fl_vec), .hit(fl_hit), .hit_idx(fl_idx));
    ab_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_iv_match (
        .live(live), .tags(tag_q), .key(inv_in_tag),
        .hit_vec(iv_vec), .hit(iv_hit), .hit_idx(iv_idx));

    logic [IDX_W-1:0] victim_idx;
    logic             touch_en;
    logic [IDX_W-1:0] touch_idx;
    logic             st_take, fill_take, inv_take, ld_take, fill_remote;

    assign fill_remote = fill_tag[CL_W-1:0] != CL_W'(CLUSTER_ID);
    assign st_take     = !flush && st_valid && st_hit;
    assign inv_take    = !flush && inv_in_valid && iv_hit;
    assign ld_take     = !flush && ld_req;
    assign fill_take   = !flush && fill_valid && fill_remote && !fl_hit
                       && !(inv_in_valid && inv_in_tag == fill_tag)
                       && !(st_take && victim_idx == st_idx);

    always_comb begin
        touch_en  = 1'b0;
        touch_idx = '0;
        if (fill_take) begin
            touch_en  = 1'b1;
            touch_idx = victim_idx;
        end else if (st_take) begin
            touch_en  = 1'b1;
            touch_idx = st_idx;
        end else if (ld_take && ld_hit) begin
            touch_en  = 1'b1;
            touch_idx = ld_idx;
        end
    end

    ab_lru #(.ENTRIES(ENTRIES)) u_lru (
        .clk(clk), .rst(rst), .touch_en(touch_en), .touch_idx(touch_idx),
        .live(live), .victim_idx(victim_idx));

    // entry storage: store, then invalidate, then fill (later wins)
    always_ff @(posedge clk) begin
        if (rst || flush) begin
            for (int e = 0; e < ENTRIES; e++) state_q[e] <= LINE_EMPTY;
        end else begin
            if (st_take) state_q[st_idx] <= LINE_OWNED;
            if (inv_take) state_q[iv_idx] <= LINE_EMPTY;
            if (fill_take) state_q[victim_idx] <= LINE_SHARED;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q <= '0;
            for (int e = 0; e < ENTRIES; e++)
                for (int w = 0; w < WORDS; w++) data_q[e][w] <= '0;
        end else begin
            if (st_take) data_q[st_idx][st_ws] <= st_data;
            if (fill_take) begin
                tag_q[victim_idx] <= fill_tag;
                for (int w = 0; w < WORDS; w++)
                    data_q[victim_idx][w] <= fill_data[w*DATA_W +: DATA_W];
            end
        end
    end

    // response and broadcast registers
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q  <= '0;
            inv_q <= '0;
        end else begin
            rd_q.valid <= ld_take;
            rd_q.hit   <= ld_take && ld_hit;
            rd_q.data  <= (ld_take && ld_hit) ? data_q[ld_idx][ld_ws] : '0;
            inv_q.valid <= st_take;
            inv_q.tag   <= st_take ? st_tag : '0;
        end
    end

    assign ld_stall      = flush;
    assign rd_valid      = rd_q.valid;
    assign rd_hit        = rd_q.hit;
    assign rd_data       = rd_q.data;
    assign inv_out_valid = inv_q.valid;
    assign inv_out_tag   = inv_q.tag;

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!rd_valid && !inv_out_valid));
    // R3
    hit_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        rd_hit |-> rd_valid);
    // R5
    no_duplicate_tag_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ld_vec) && $onehot0(st_vec) && $onehot0(fl_vec) && $onehot0(iv_vec));
    // R6
    store_broadcast_chk: assert property (@(posedge clk) disable iff (rst)
        (st_valid && st_hit && !flush) |=> inv_out_valid);
    // R9
    flush_empties_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (live == '0 && !rd_valid));
endmodule

// File: tb/sim_attraction_buffer.sv
`timescale 1ns/1ps
module sim_attraction_buffer;
    localparam int NC = 4, CID = 1, WD = 2, NE = 4, AW = 10, DW = 16;
    localparam int TW = AW - 1;

    logic clk = 1'b0, rst = 1'b1, flush = 1'b0;
    logic ld_stall, ld_req = 1'b0, rd_valid, rd_hit;
    logic [AW-1:0] ld_addr = '0, st_addr = '0;
    logic [DW-1:0] rd_data, st_data = '0;
    logic fill_valid = 1'b0, st_valid = 1'b0, inv_in_valid = 1'b0, inv_out_valid;
    logic [TW-1:0] fill_tag = '0, inv_in_tag = '0, inv_out_tag;
    logic [WD*DW-1:0] fill_data = '0;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    attraction_buffer #(.NUM_CLUSTERS(NC), .CLUSTER_ID(CID), .WORDS(WD),
        .ENTRIES(NE), .ADDR_W(AW), .DATA_W(DW)) u0 (
        .clk(clk), .rst(rst), .flush(flush), .ld_stall(ld_stall),
        .ld_req(ld_req), .ld_addr(ld_addr), .rd_valid(rd_valid), .rd_hit(rd_hit),
        .rd_data(rd_data), .fill_valid(fill_valid), .fill_tag(fill_tag),
        .fill_data(fill_data), .st_valid(st_valid), .st_addr(st_addr),
        .st_data(st_data), .inv_in_valid(inv_in_valid), .inv_in_tag(inv_in_tag),
        .inv_out_valid(inv_out_valid), .inv_out_tag(inv_out_tag));

    function automatic logic [DW-1:0] pat(logic [AW-1:0] a);
        return 16'hA000 + 16'(a) * 16'd7;
    endfunction

    function automatic logic [TW-1:0] tag_of(logic [AW-1:0] a);
        return {a[AW-1:3], a[1:0]};
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    // fill the subblock containing address a; mask corrupts the data
    task automatic do_fill(logic [AW-1:0] a, logic [DW-1:0] mask);
        @(negedge clk);
        fill_valid = 1'b1;
        fill_tag   = tag_of(a);
        fill_data  = {pat(a | 10'd4) ^ mask, pat(a & ~10'd4) ^ mask};
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic do_load(logic [AW-1:0] a, bit exp_hit, logic [DW-1:0] exp_d, string req);
        @(negedge clk);
        ld_req = 1'b1; ld_addr = a;
        @(negedge clk);
        ld_req = 1'b0;
        check(rd_valid == 1'b1, req, int'(rd_valid), 1);
        check(rd_hit == exp_hit && rd_data == (exp_hit ? exp_d : '0), req,
              int'({rd_hit, rd_data}), int'({exp_hit, exp_hit ? exp_d : 16'h0}));
    endtask

    task automatic do_store(logic [AW-1:0] a, logic [DW-1:0] d);
        @(negedge clk);
        st_valid = 1'b1; st_addr = a; st_data = d;
        @(negedge clk);
        st_valid = 1'b0;
    endtask

    task automatic do_inv(logic [TW-1:0] t);
        @(negedge clk);
        inv_in_valid = 1'b1; inv_in_tag = t;
        @(negedge clk);
        inv_in_valid = 1'b0;
    endtask

    // {address, expected hit}; subblocks 3/7, 8/12, 18/22 filled, 5 local, 11 absent
    localparam logic [AW:0] TBL [10] = '{
        {10'd3, 1'b1}, {10'd7, 1'b1}, {10'd8, 1'b1}, {10'd12, 1'b1},
        {10'd18, 1'b1}, {10'd22, 1'b1}, {10'd5, 1'b0}, {10'd11, 1'b0},
        {10'd0, 1'b0}, {10'd26, 1'b0}};

    initial begin
        #(5.0 * 50000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            report();
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: reset state
        check(!rd_valid && !inv_out_valid && !ld_stall, "R1", int'({rd_valid, inv_out_valid}), 0);
        do_load(10'd3, 1'b0, '0, "R1 empty after reset");

        // R2: capture remote subblock, partner word served
        do_fill(10'd3, '0);
        do_load(10'd7, 1'b1, pat(10'd7), "R2 partner word");
        do_load(10'd3, 1'b1, pat(10'd3), "R2 missed word");

        // R4: local-home fill ignored
        do_fill(10'd5, '0);
        do_load(10'd5, 1'b0, '0, "R4 local fill");

        // R3: table of lookups
        do_fill(10'd8, '0);
        do_fill(10'd18, '0);
        do_reset();
        do_fill(10'd3, '0); do_fill(10'd8, '0); do_fill(10'd18, '0);
        for (int i = 0; i < 10; i++)
            do_load(TBL[i][AW:1], TBL[i][0], pat(TBL[i][AW:1]), "R3 table");

        // R5: refill of held tag keeps data
        do_fill(10'd3, 16'hFFFF);
        do_load(10'd3, 1'b1, pat(10'd3), "R5 shared refill");

        // R6: store hit broadcasts and updates
        do_store(10'd7, 16'h1234);
        check(inv_out_valid && inv_out_tag == tag_of(10'd7), "R6 broadcast",
              int'({inv_out_valid, inv_out_tag}), int'({1'b1, tag_of(10'd7)}));
        @(negedge clk);
        check(!inv_out_valid, "R6 single pulse", int'(inv_out_valid), 0);
        do_load(10'd7, 1'b1, 16'h1234, "R6 stored word");
        do_load(10'd3, 1'b1, pat(10'd3), "R6 other word kept");
        do_store(10'd11, 16'h4321);
        check(!inv_out_valid, "R6 store miss", int'(inv_out_valid), 0);
        do_load(10'd11, 1'b0, '0, "R6 store miss no alloc");
        do_fill(10'd3, 16'h0F0F);
        do_load(10'd7, 1'b1, 16'h1234, "R5 owned refill");

        // R7: invalidates
        do_inv(tag_of(10'd8));
        do_load(10'd12, 1'b0, '0, "R7 shared dropped");
        do_inv(tag_of(10'd7));
        do_load(10'd7, 1'b0, '0, "R7 owned dropped");
        @(negedge clk);
        fill_valid = 1'b1; fill_tag = tag_of(10'd26);
        fill_data = {pat(10'd30), pat(10'd26)};
        inv_in_valid = 1'b1; inv_in_tag = tag_of(10'd26);
        @(negedge clk);
        fill_valid = 1'b0; inv_in_valid = 1'b0;
        do_load(10'd26, 1'b0, '0, "R7 inv beats fill");

        // R8: LRU replacement
        do_reset();
        do_fill(10'd3, '0); do_fill(10'd8, '0); do_fill(10'd18, '0); do_fill(10'd27, '0);
        do_load(10'd3, 1'b1, pat(10'd3), "R8 touch oldest");
        do_fill(10'd35, '0);
        do_load(10'd8, 1'b0, '0, "R8 lru evicted");
        do_load(10'd35, 1'b1, pat(10'd35), "R8 new entry");
        do_load(10'd3, 1'b1, pat(10'd3), "R8 touched kept");
        do_load(10'd22, 1'b1, pat(10'd22), "R8 kept");
        do_load(10'd31, 1'b1, pat(10'd31), "R8 kept");

        // R9: flush
        @(negedge clk);
        flush = 1'b1; ld_req = 1'b1; ld_addr = 10'd3;
        fill_valid = 1'b1; fill_tag = tag_of(10'd11);
        fill_data = {pat(10'd15), pat(10'd11)};
        #1;
        check(ld_stall, "R9 stall", int'(ld_stall), 1);
        @(negedge clk);
        flush = 1'b0; ld_req = 1'b0; fill_valid = 1'b0;
        check(!rd_valid, "R9 no result", int'(rd_valid), 0);
        check(!ld_stall, "R9 stall released", int'(ld_stall), 0);
        do_load(10'd3, 1'b0, '0, "R9 emptied");
        do_load(10'd35, 1'b0, '0, "R9 emptied");
        do_load(10'd11, 1'b0, '0, "R9 fill ignored");

        done = 1'b1;
        report();
        $finish;
    end
endmodule